// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags

This block receives asynchronous serial frames on a single line and hands each recovered byte to its consumer through a one-entry buffer. A frame is a low start bit, eight data bits sent least significant first, an optional parity bit and a high stop bit. A baud tick pulse, one clock wide and arriving sixteen times per bit period, paces the receiver. Inside each bit period the receiver counts ticks from 0 to 15. It takes the line value at ticks 7, 8 and 9 and settles the bit by majority vote.

The line passes through a two-flop synchronizer. A falling edge seen while the receiver is idle and enabled starts a frame. A state machine with five states runs the frame. RX_IDLE goes to RX_START on a falling edge while enabled. RX_START goes to RX_DATA when the start bit votes 0, and back to RX_IDLE when it votes 1 (a false start). RX_DATA stays in place until the last data bit is voted, then goes to RX_PARITY if parity is on or to RX_STOP if it is off. RX_PARITY goes to RX_STOP once its bit is voted. RX_STOP goes to RX_IDLE as soon as the stop bit is voted at tick 9, without waiting out the rest of the bit. Every state other than RX_IDLE falls back to RX_IDLE whenever the enable drops.

At frame completion the byte and its status go to the buffer in a single clock edge. The status covers noise, parity and framing. If the buffer is still full at that point, the new frame is dropped and only an overrun flag is added. A read strobe empties the buffer and clears every flag.

Top module: `uart_os_rx`

## Requirements
- R1: Each bit takes the majority value of the synchronized line at ticks 7, 8 and 9 of its 16-tick period, so one disagreeing sample among the three does not change the bit.
- R2: If the three samples of any bit in a completed frame are not all equal, the noise flag is raised with that frame. This applies to the start, data, parity and stop bits.
- R3: With parity enabled at frame start, even parity (select 0) expects the parity bit to equal the XOR of the data bits, and odd parity (select 1) expects its inverse. A mismatch raises the parity flag. With parity disabled, the stop bit follows the eighth data bit directly.
- R4: A stop bit voted 0 raises the framing flag. The byte is still stored.
- R5: A frame that completes while the buffer is full leaves the stored byte and its noise, parity and framing flags unchanged, and sets the overrun flag.
- R6: The full, noise, parity and framing flags of a stored frame all rise on the same clock edge.
- R7: A read strobe with no frame completing in that cycle clears full, noise, parity, framing and overrun.
- R8: Dropping the enable during a frame abandons it, with no flags raised and nothing stored. While the enable is low, line activity is ignored.
- R9: A start bit that votes 1 returns the receiver to idle without storing anything. The next valid frame is then received normally.
- R10: The receiver is idle immediately after the stop bit's tick-9 vote. A following start edge at tick 10 of the stop bit begins a new frame.
- R11: After reset the data output is 0 and every flag is 0.
- R12: The first data bit received lands in bit 0 of the data output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| tick_i | input | 1 | Sample tick pulse, 16 per bit period |
| rx_en_i | input | 1 | Receive enable |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | Parity select: 0 even, 1 odd |
| rd_i | input | 1 | Read strobe, empties the buffer |
| data_o | output | 8 | Buffered received byte |
| full_o | output | 1 | Buffer holds an unread byte |
| noise_o | output | 1 | Noise seen in the buffered frame |
| perr_o | output | 1 | Parity mismatch in the buffered frame |
| ferr_o | output | 1 | Stop bit was low in the buffered frame |
| ovr_o | output | 1 | A frame was lost while the buffer was full |

## Verification
The bench flips a single centre sample inside the start, a data, the parity and the stop bit. A design that took one sample instead of a vote would return a wrong byte, and one that watched only the data bits would miss the noise flag. It sends back-to-back frames with no read in between and expects the first byte to survive with the overrun flag set; a design that overwrote the buffer would show the second byte. It cuts the stop bit short at tick 10 to catch a receiver that waits out the whole stop bit. It drops the enable in mid-frame, and it sends a start pulse too short to win the vote; a design that kept going in either case would store a bogus byte.

// File: rtl/osrx_pkg.sv
package osrx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/osrx_sync.sv
module osrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic rx_s_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            last_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], rx_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rx_s_o = chain_q[STAGES-1];
    assign fall_o = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/osrx_voter.sv
module osrx_voter #(
    parameter int OSR        = 16,
    parameter int MID_SAMPLE = 8,
    parameter int CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             active_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             rx_i,
    output logic             decide_o,
    output logic             vote_o,
    output logic             noise_o
);
    localparam logic [CNT_W-1:0] S_FIRST = CNT_W'(MID_SAMPLE - 1);
    localparam logic [CNT_W-1:0] S_MID   = CNT_W'(MID_SAMPLE);
    localparam logic [CNT_W-1:0] S_LAST  = CNT_W'(MID_SAMPLE + 1);

    logic samp_a_q, samp_b_q;
    logic hit;

    assign hit = tick_i & active_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_a_q <= 1'b1;
            samp_b_q <= 1'b1;
        end else if (hit) begin
            if (cnt_i == S_FIRST) samp_a_q <= rx_i;
            if (cnt_i == S_MID)   samp_b_q <= rx_i;
        end
    end

    assign decide_o = hit && (cnt_i == S_LAST);
    assign vote_o   = (samp_a_q & samp_b_q) | (samp_a_q & rx_i) | (samp_b_q & rx_i);
    assign noise_o  = (samp_a_q != samp_b_q) || (samp_b_q != rx_i);
endmodule

// File: rtl/osrx_buffer.sv
module osrx_buffer #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done_i,
    input  logic [DATA_BITS-1:0] data_i,
    input  logic                 noise_i,
    input  logic                 perr_i,
    input  logic                 ferr_i,
    input  logic                 rd_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 full_o,
    output logic                 noise_o,
    output logic                 perr_o,
    output logic                 ferr_o,
    output logic                 ovr_o
);
    logic [DATA_BITS-1:0] data_q;
    logic full_q, noise_q, perr_q, ferr_q, ovr_q;
    logic still_full;

    assign still_full = full_q & ~rd_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            full_q  <= 1'b0;
            noise_q <= 1'b0;
            perr_q  <= 1'b0;
            ferr_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else if (done_i) begin
            if (still_full) begin
                ovr_q <= 1'b1;
            end else begin
                data_q  <= data_i;
                full_q  <= 1'b1;
                noise_q <= noise_i;
                perr_q  <= perr_i;
                ferr_q  <= ferr_i;
                ovr_q   <= 1'b0;
            end
        end else if (rd_i) begin
            full_q  <= 1'b0;
            noise_q <= 1'b0;
            perr_q  <= 1'b0;
            ferr_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end
    end

    assign data_o  = data_q;
    assign full_o  = full_q;
    assign noise_o = noise_q;
    assign perr_o  = perr_q;
    assign ferr_o  = ferr_q;
    assign ovr_o   = ovr_q;

    // R6
    flags_with_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(noise_q) || $rose(perr_q) || $rose(ferr_q)) |-> $rose(full_q));

    // R7
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !done_i) |=> (!full_q && !ovr_q && !noise_q && !perr_q && !ferr_q));

    // R5
    keep_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && full_q && !rd_i) |=> (full_q && ovr_q && $stable(data_q)));
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
    parameter int DATA_BITS   = 8,
    parameter int OSR         = 16,
    parameter int MID_SAMPLE  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_i,
    input  logic                 tick_i,
    input  logic                 rx_en_i,
    input  logic                 par_en_i,
    input  logic                 par_odd_i,
    input  logic                 rd_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 full_o,
    output logic                 noise_o,
    output logic                 perr_o,
    output logic                 ferr_o,
    output logic                 ovr_o
);
    import osrx_pkg::*;

    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

    rx_state_e st_q, st_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [IDX_W-1:0]     idx_q;
    logic [DATA_BITS-1:0] sh_q;
    logic pen_q, podd_q, nacc_q, perr_q;
    logic rx_s, rx_fall;
    logic active, decide, vote, vnoise, done;

    osrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (rx_i),
        .rx_s_o (rx_s),
        .fall_o (rx_fall)
    );

    assign active = (st_q != RX_IDLE);

    osrx_voter #(.OSR(OSR), .MID_SAMPLE(MID_SAMPLE), .CNT_W(CNT_W)) u_voter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .active_i (active),
        .cnt_i    (cnt_q),
        .rx_i     (rx_s),
        .decide_o (decide),
        .vote_o   (vote),
        .noise_o  (vnoise)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_IDLE:   if (rx_en_i && rx_fall) st_d = RX_START;
            RX_START:  if (decide) st_d = vote ? RX_IDLE : RX_DATA;
            RX_DATA:   if (decide && idx_q == IDX_LAST) st_d = pen_q ? RX_PARITY : RX_STOP;
            RX_PARITY: if (decide) st_d = RX_STOP;
            RX_STOP:   if (decide) st_d = RX_IDLE;
            default:   st_d = RX_IDLE;
        endcase
        if (!rx_en_i) st_d = RX_IDLE;
    end

    // Frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            sh_q   <= '0;
            pen_q  <= 1'b0;
            podd_q <= 1'b0;
            nacc_q <= 1'b0;
            perr_q <= 1'b0;
        end else if (st_q == RX_IDLE) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            nacc_q <= 1'b0;
            perr_q <= 1'b0;
            pen_q  <= par_en_i;
            podd_q <= par_odd_i;
        end else begin
            if (tick_i) cnt_q <= (cnt_q == CNT_MAX) ? '0 : cnt_q + 1'b1;
            if (decide) begin
                nacc_q <= nacc_q | vnoise;
                if (st_q == RX_DATA) begin
                    sh_q  <= {vote, sh_q[DATA_BITS-1:1]};
                    idx_q <= idx_q + 1'b1;
                end
                if (st_q == RX_PARITY)
                    perr_q <= (vote != ((^sh_q) ^ podd_q));
            end
        end
    end

    assign done = decide && (st_q == RX_STOP) && rx_en_i;

    osrx_buffer #(.DATA_BITS(DATA_BITS)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (done),
        .data_i  (sh_q),
        .noise_i (nacc_q | vnoise),
        .perr_i  (perr_q),
        .ferr_i  (~vote),
        .rd_i    (rd_i),
        .data_o  (data_o),
        .full_o  (full_o),
        .noise_o (noise_o),
        .perr_o  (perr_o),
        .ferr_o  (ferr_o),
        .ovr_o   (ovr_o)
    );

    // R8
    en_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_i |=> (st_q == RX_IDLE));

    // R10
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (st_q == RX_IDLE));
endmodule

// File: tb/uart_os_rx_tb.sv
module uart_os_rx_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx = 1'b1, tick = 1'b0, en = 1'b1, pen = 1'b0, podd = 1'b0, rd = 1'b0;
    logic [7:0] data;
    logic full, noise, perr, ferr, ovr;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    uart_os_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick), .rx_en_i(en),
        .par_en_i(pen), .par_odd_i(podd), .rd_i(rd),
        .data_o(data), .full_o(full), .noise_o(noise), .perr_o(perr),
        .ferr_o(ferr), .ovr_o(ovr)
    );

    // Vector: [15:8] data, [7] parity on, [6] odd, [5] corrupt parity,
    // [4] stop level, [3:0] noisy bit (0 start, 1..8 data, 9 parity, 10 stop, 15 none)
    localparam int NV = 9;
    localparam logic [15:0] VEC [NV] = '{
        {8'hA5, 1'b1, 1'b0, 1'b0, 1'b1, 4'd15},
        {8'h3C, 1'b1, 1'b1, 1'b0, 1'b1, 4'd15},
        {8'h01, 1'b1, 1'b0, 1'b1, 1'b1, 4'd15},
        {8'hFE, 1'b1, 1'b1, 1'b1, 1'b1, 4'd15},
        {8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 4'd15},
        {8'h80, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8},
        {8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0},
        {8'hFF, 1'b1, 1'b0, 1'b0, 1'b1, 4'd9},
        {8'h69, 1'b0, 1'b0, 1'b0, 1'b1, 4'd10}
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic slot(input logic v);
        @(negedge clk) begin rx = v; tick = 1'b0; end
        @(negedge clk);
        @(negedge clk);
        @(negedge clk) tick = 1'b1;
    endtask

    task automatic bit_slots(input logic v, input bit noisy, input int len);
        for (int k = 0; k < len; k++) slot((noisy && k == 8) ? ~v : v);
    endtask

    task automatic settle();
        @(negedge clk) tick = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) slot(1'b1);
        settle();
    endtask

    task automatic send(input logic [7:0] d, input logic pe, input logic po,
                        input logic badp, input logic stopv, input int nb, input int stop_len);
        pen = pe; podd = po;
        bit_slots(1'b0, nb == 0, 16);
        for (int i = 0; i < 8; i++) bit_slots(d[i], nb == i + 1, 16);
        if (pe) bit_slots((^d) ^ po ^ badp, nb == 9, 16);
        bit_slots(stopv, nb == 10, stop_len);
    endtask

    task automatic do_read();
        @(negedge clk) begin rd = 1'b1; tick = 1'b0; end
        @(negedge clk) rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_clear(input string tag);
        check({3'b0, full, noise, perr, ferr, ovr}, 8'h00, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        check(data, 8'h00, "R11 data after reset");
        check_clear("R11 flags after reset");
        rst_n = 1'b1;
        idle(4);

        // Table walk: R1 R2 R3 R4 R12
        for (int v = 0; v < NV; v++) begin
            logic [7:0] d;
            int nb;
            d  = VEC[v][15:8];
            nb = int'(VEC[v][3:0]);
            send(d, VEC[v][7], VEC[v][6], VEC[v][5], VEC[v][4], (nb == 15) ? -1 : nb, 16);
            idle(3);
            check(data, d, "R1 R12 data value");
            check({7'b0, full}, 8'h01, "R6 full set");
            check({7'b0, noise}, {7'b0, nb != 15}, "R2 noise flag");
            check({7'b0, perr}, {7'b0, VEC[v][7] & VEC[v][5]}, "R3 parity flag");
            check({7'b0, ferr}, {7'b0, ~VEC[v][4]}, "R4 framing flag");
            check({7'b0, ovr}, 8'h00, "R5 no overrun");
            do_read();
            check_clear("R7 read clears all");
        end

        // R5: overrun keeps old frame
        send(8'h11, 1'b0, 1'b0, 1'b0, 1'b1, -1, 16);
        send(8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 3, 16);
        idle(3);
        check(data, 8'h11, "R5 old data kept");
        check({6'b0, full, ovr}, 8'h03, "R5 full and overrun");
        check({6'b0, noise, ferr}, 8'h00, "R5 old flags kept");
        do_read();
        check_clear("R7 clear after overrun");

        // R8: disable mid-frame
        pen = 1'b0;
        bit_slots(1'b0, 1'b0, 16);
        bit_slots(1'b1, 1'b0, 16);
        bit_slots(1'b1, 1'b0, 16);
        en = 1'b0;
        bit_slots(1'b0, 1'b0, 16);
        for (int i = 0; i < 6; i++) bit_slots(1'b1, 1'b0, 16);
        idle(4);
        en = 1'b1;
        idle(20);
        check_clear("R8 abandoned frame stores nothing");

        // R8: enable low ignores a full frame
        en = 1'b0;
        send(8'h77, 1'b0, 1'b0, 1'b0, 1'b1, -1, 16);
        idle(3);
        en = 1'b1;
        idle(3);
        check_clear("R8 disabled receiver ignores line");

        // R9: false start then a valid frame
        bit_slots(1'b0, 1'b0, 6);
        idle(30);
        check_clear("R9 false start stores nothing");
        send(8'h42, 1'b0, 1'b0, 1'b0, 1'b1, -1, 16);
        idle(3);
        check(data, 8'h42, "R9 frame after false start");
        check({7'b0, full}, 8'h01, "R9 full after false start");
        do_read();

        // R10: stop bit cut at tick 10, next frame follows at once
        send(8'h81, 1'b0, 1'b0, 1'b0, 1'b1, -1, 10);
        send(8'h7E, 1'b0, 1'b0, 1'b0, 1'b1, -1, 16);
        idle(3);
        check(data, 8'h81, "R10 first frame kept");
        check({6'b0, full, ovr}, 8'h03, "R10 second frame completed");
        check({6'b0, noise, ferr}, 8'h00, "R10 no spurious errors");
        do_read();
        check_clear("R7 final clear");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule